// File: doc/BRIEF.md
# Descriptor Ring Walker

This block drives one DMA channel through a ring of descriptors held in memory. A control block loads a 64-bit head pointer, the ring length in elements, an initial cycle state and a recycle enable, then pulses `start`. The walker fetches each descriptor as four 64-bit words through a single-outstanding memory read port. It compares the descriptor's cycle bit with its own cycle state. It hands each valid descriptor to a data mover on a valid/ready transfer port and waits for a done pulse before it fetches the next descriptor.

The last element of a ring of N elements is not a descriptor. It holds a pointer back to the head of the ring. After element N-2 the walker reads that pointer and continues at element 0. When recycling is enabled it also inverts its cycle state at that point. Software can therefore refill finished entries with the opposite cycle value while the channel works on later entries. A descriptor whose cycle bit does not match stops the walk and raises the empty flag.

Back-pressure works the same way on both streaming edges. The memory read request holds its address, and the transfer port holds its payload, for as long as valid is high and ready is low. The read response has no ready: it is accepted in any cycle while a read is outstanding.

Top module: `ring_desc_walker`

## Requirements
- R1: After reset, `busy`, `err`, `empty`, `irq`, `rd_req_valid` and `xfer_valid` are all 0.
- R2: A `start` with `cfg_len` below 2 sets `err` in the next cycle. It issues no read and leaves `busy` at 0. The next legal `start` clears `err`.
- R3: Element k of a ring at head address H starts at byte address H+32k. Its four words are read in order at offsets +0, +8, +16 and +24. These words are: control (bit 0 is the cycle bit, bit 1 is the interrupt flag), size (bits 31:0), source address and destination address.
- R4: If the control word's cycle bit differs from the current cycle state, the walker fetches no further word of that element and issues no transfer. It returns to idle with `empty` at 1.
- R5: Only one descriptor is offered at a time. No memory read is issued from the moment the transfer is offered until the cycle after its `xfer_done`.
- R6: `irq` pulses for exactly one cycle, in the cycle after the `xfer_done` that completes a descriptor whose interrupt flag is set. It stays 0 otherwise.
- R7: After element N-2 completes, the walker reads the pointer word at offset +16 of element N-1 and continues at that address as element 0. For N=4 the elements run 0,1,2,0,...
- R8: When following the link, the cycle state inverts if recycling is enabled and is kept if it is disabled.
- R9: An element rewritten by software with the new cycle value before the walker reaches it again is consumed on the next lap.
- R10: With N=2 the single descriptor is followed directly by the link read on every lap.
- R11: While `rd_req_valid` is high and `rd_req_ready` is low, `rd_req_valid` stays high and `rd_req_addr` stays stable. While `xfer_valid` is high and `xfer_ready` is low, the transfer payload stays stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a walk using the cfg inputs |
| cfg_head | input | 64 | Byte address of ring element 0 |
| cfg_len | input | 16 | Ring length in elements, link element included |
| cfg_cycle | input | 1 | Initial cycle state |
| cfg_recycle | input | 1 | Invert cycle state on each wrap |
| rd_req_valid | output | 1 | Memory read request valid |
| rd_req_ready | input | 1 | Memory read request accepted |
| rd_req_addr | output | 64 | Byte address of the 64-bit word to read |
| rd_rsp_valid | input | 1 | Read data valid |
| rd_rsp_data | input | 64 | Read data |
| xfer_valid | output | 1 | Descriptor offered to the data mover |
| xfer_ready | input | 1 | Data mover accepts the descriptor |
| xfer_src | output | 64 | Source address |
| xfer_dst | output | 64 | Destination address |
| xfer_size | output | 32 | Transfer size |
| xfer_done | input | 1 | Accepted transfer finished (one-cycle pulse) |
| irq | output | 1 | Completion event for flagged descriptors |
| busy | output | 1 | Walk in progress |
| empty | output | 1 | Walk stopped on a cycle-bit mismatch |
| err | output | 1 | Start rejected for a ring shorter than 2 |

## Verification
`err` rises one cycle after the `start` edge, and `irq` is high in exactly the one cycle after the `xfer_done` edge. The bench drives every input at the falling edge and samples one half-period after the edge that is meant to update the output, so each check lands in the cycle the output is due. Read ordering and addresses cannot be tied to fixed cycles because the memory model throttles `rd_req_ready`. They are therefore checked from a log of accepted requests once `busy` falls. The transfer payload is sampled over two stalled cycles before `xfer_ready` is raised. The absence of reads is sampled across the three cycles before `xfer_done`.

// File: rtl/rdw_pkg.sv
package rdw_pkg;
  localparam int WORD_BYTES = 8;
  localparam int DESC_WORDS = 4;
  localparam int LINK_WORD  = 2;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_FETCH,
    ST_EXEC,
    ST_LINK
  } rdw_state_t;
endpackage

// File: rtl/rdw_rd_port.sv
module rdw_rd_port #(
  parameter int ADDR_W = 64,
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              want,
  input  logic [ADDR_W-1:0] addr,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [ADDR_W-1:0] req_addr,
  input  logic              rsp_valid,
  input  logic [DATA_W-1:0] rsp_data,
  output logic              done,
  output logic [DATA_W-1:0] data
);
  logic wait_q;
  logic done_q;
  logic [DATA_W-1:0] data_q;

  assign req_valid = want && !wait_q && !done_q;
  assign req_addr  = addr;
  assign done      = done_q;
  assign data      = data_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wait_q <= 1'b0;
      done_q <= 1'b0;
      data_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (req_valid && req_ready) wait_q <= 1'b1;
      if (wait_q && rsp_valid) begin
        wait_q <= 1'b0;
        done_q <= 1'b1;
        data_q <= rsp_data;
      end
    end
  end

  // R11
  rd_addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_addr));
endmodule

// File: rtl/rdw_xfer_port.sv
module rdw_xfer_port #(
  parameter int ADDR_W = 64,
  parameter int SIZE_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] src_in,
  input  logic [ADDR_W-1:0] dst_in,
  input  logic [SIZE_W-1:0] size_in,
  output logic              valid,
  input  logic              ready,
  output logic [ADDR_W-1:0] src,
  output logic [ADDR_W-1:0] dst,
  output logic [SIZE_W-1:0] size,
  input  logic              done_in,
  output logic              fin
);
  logic valid_q;
  logic inflight_q;

  assign valid = valid_q;
  assign fin   = inflight_q && done_in;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q    <= 1'b0;
      inflight_q <= 1'b0;
      src        <= '0;
      dst        <= '0;
      size       <= '0;
    end else begin
      if (load) begin
        valid_q <= 1'b1;
        src     <= src_in;
        dst     <= dst_in;
        size    <= size_in;
      end else if (valid_q && ready) begin
        valid_q    <= 1'b0;
        inflight_q <= 1'b1;
      end
      if (fin) inflight_q <= 1'b0;
    end
  end

  // R11
  xfer_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid && !ready |=> valid && $stable(src) && $stable(dst) && $stable(size));
  // R5
  one_desc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> !inflight_q);
endmodule

// File: rtl/ring_desc_walker.sv
module ring_desc_walker #(
  parameter int ADDR_W = 64,
  parameter int DATA_W = 64,
  parameter int SIZE_W = 32,
  parameter int LEN_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] cfg_head,
  input  logic [LEN_W-1:0]  cfg_len,
  input  logic              cfg_cycle,
  input  logic              cfg_recycle,
  output logic              rd_req_valid,
  input  logic              rd_req_ready,
  output logic [ADDR_W-1:0] rd_req_addr,
  input  logic              rd_rsp_valid,
  input  logic [DATA_W-1:0] rd_rsp_data,
  output logic              xfer_valid,
  input  logic              xfer_ready,
  output logic [ADDR_W-1:0] xfer_src,
  output logic [ADDR_W-1:0] xfer_dst,
  output logic [SIZE_W-1:0] xfer_size,
  input  logic              xfer_done,
  output logic              irq,
  output logic              busy,
  output logic              empty,
  output logic              err
);
  import rdw_pkg::*;

  localparam int WB_SH      = $clog2(WORD_BYTES);
  localparam int DESC_BYTES = WORD_BYTES * DESC_WORDS;
  localparam int LINK_OFS   = DESC_BYTES + LINK_WORD * WORD_BYTES;
  localparam int WIDX_W     = $clog2(DESC_WORDS);

  rdw_state_t        st;
  logic [ADDR_W-1:0] cur_addr;
  logic [LEN_W-1:0]  idx;
  logic [LEN_W-1:0]  len_q;
  logic              cyc_q;
  logic              recyc_q;
  logic [WIDX_W-1:0] widx;
  logic              flag_q;
  logic [SIZE_W-1:0] size_q;
  logic [ADDR_W-1:0] src_q;
  logic              err_q;
  logic              empty_q;
  logic              irq_q;

  logic              rd_want;
  logic [ADDR_W-1:0] rd_addr;
  logic              rd_done;
  logic [DATA_W-1:0] rd_data;
  logic              xf_load;
  logic              xf_fin;

  assign rd_want = (st == ST_FETCH) || (st == ST_LINK);
  assign rd_addr = (st == ST_LINK) ? cur_addr + ADDR_W'(LINK_OFS)
                                   : cur_addr + (ADDR_W'(widx) << WB_SH);
  assign xf_load = (st == ST_FETCH) && rd_done && (widx == WIDX_W'(DESC_WORDS - 1));

  assign busy  = (st != ST_IDLE);
  assign empty = empty_q;
  assign err   = err_q;
  assign irq   = irq_q;

  rdw_rd_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rd (
    .clk(clk), .rst_n(rst_n), .want(rd_want), .addr(rd_addr),
    .req_valid(rd_req_valid), .req_ready(rd_req_ready), .req_addr(rd_req_addr),
    .rsp_valid(rd_rsp_valid), .rsp_data(rd_rsp_data),
    .done(rd_done), .data(rd_data)
  );

  rdw_xfer_port #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) u_xf (
    .clk(clk), .rst_n(rst_n), .load(xf_load),
    .src_in(src_q), .dst_in(rd_data[ADDR_W-1:0]), .size_in(size_q),
    .valid(xfer_valid), .ready(xfer_ready),
    .src(xfer_src), .dst(xfer_dst), .size(xfer_size),
    .done_in(xfer_done), .fin(xf_fin)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      cur_addr <= '0;
      idx      <= '0;
      len_q    <= '0;
      cyc_q    <= 1'b0;
      recyc_q  <= 1'b0;
      widx     <= '0;
      flag_q   <= 1'b0;
      size_q   <= '0;
      src_q    <= '0;
      err_q    <= 1'b0;
      empty_q  <= 1'b0;
      irq_q    <= 1'b0;
    end else begin
      irq_q <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (start) begin
            empty_q <= 1'b0;
            if (cfg_len < LEN_W'(2)) begin
              err_q <= 1'b1;
            end else begin
              err_q    <= 1'b0;
              cur_addr <= cfg_head;
              len_q    <= cfg_len;
              idx      <= '0;
              widx     <= '0;
              cyc_q    <= cfg_cycle;
              recyc_q  <= cfg_recycle;
              st       <= ST_FETCH;
            end
          end
        end
        ST_FETCH: begin
          if (rd_done) begin
            widx <= widx + 1'b1;
            case (widx)
              2'd0: begin
                if (rd_data[0] != cyc_q) begin
                  empty_q <= 1'b1;
                  st      <= ST_IDLE;
                end
                flag_q <= rd_data[1];
              end
              2'd1: size_q <= rd_data[SIZE_W-1:0];
              2'd2: src_q  <= rd_data[ADDR_W-1:0];
              default: st  <= ST_EXEC;
            endcase
          end
        end
        ST_EXEC: begin
          if (xf_fin) begin
            irq_q <= flag_q;
            widx  <= '0;
            if (idx == len_q - LEN_W'(2)) begin
              st <= ST_LINK;
            end else begin
              idx      <= idx + 1'b1;
              cur_addr <= cur_addr + ADDR_W'(DESC_BYTES);
              st       <= ST_FETCH;
            end
          end
        end
        default: begin
          if (rd_done) begin
            cur_addr <= rd_data[ADDR_W-1:0];
            idx      <= '0;
            widx     <= '0;
            if (recyc_q) cyc_q <= ~cyc_q;
            st <= ST_FETCH;
          end
        end
      endcase
    end
  end

  // R2
  err_no_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !rd_req_valid && !busy);
  // R4
  empty_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    empty |-> !busy && !xfer_valid);
  // R6
  irq_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(xfer_done));
  // R5
  no_read_in_exec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_valid |-> !rd_req_valid);
endmodule

// File: tb/ring_desc_walker_tb.sv
module ring_desc_walker_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [63:0] cfg_head = '0;
  logic [15:0] cfg_len = '0;
  logic        cfg_cycle = 1'b0;
  logic        cfg_recycle = 1'b0;
  logic        rd_req_valid;
  logic        rd_req_ready = 1'b0;
  logic [63:0] rd_req_addr;
  logic        rd_rsp_valid = 1'b0;
  logic [63:0] rd_rsp_data = '0;
  logic        xfer_valid;
  logic        xfer_ready = 1'b0;
  logic [63:0] xfer_src;
  logic [63:0] xfer_dst;
  logic [31:0] xfer_size;
  logic        xfer_done = 1'b0;
  logic        irq, busy, empty, err;

  int checks = 0;
  int fails = 0;
  logic [63:0] mem [0:63];
  logic [63:0] rlog [0:255];
  int log_n = 0;
  int log_base = 0;
  int cyc_cnt = 0;

  always #5 clk = ~clk;

  ring_desc_walker u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .cfg_head(cfg_head),
    .cfg_len(cfg_len), .cfg_cycle(cfg_cycle), .cfg_recycle(cfg_recycle),
    .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready),
    .rd_req_addr(rd_req_addr), .rd_rsp_valid(rd_rsp_valid),
    .rd_rsp_data(rd_rsp_data), .xfer_valid(xfer_valid),
    .xfer_ready(xfer_ready), .xfer_src(xfer_src), .xfer_dst(xfer_dst),
    .xfer_size(xfer_size), .xfer_done(xfer_done), .irq(irq),
    .busy(busy), .empty(empty), .err(err)
  );

  // memory model: throttled request ready, one-cycle response latency
  always @(posedge clk) begin
    cyc_cnt      <= cyc_cnt + 1;
    rd_req_ready <= (cyc_cnt % 3) != 0;
    rd_rsp_valid <= 1'b0;
    if (rd_req_valid && rd_req_ready) begin
      rd_rsp_valid <= 1'b1;
      rd_rsp_data  <= mem[rd_req_addr[8:3]];
      rlog[log_n]  <= rd_req_addr;
      log_n        <= log_n + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic put_desc(input logic [63:0] head, input int k, input bit cyc,
                          input bit fl, input logic [63:0] src);
    int b = int'(head[8:3]) + 4 * k;
    mem[b]     = {62'd0, fl, cyc};
    mem[b + 1] = 64'h100 + 64'(k);
    mem[b + 2] = src;
    mem[b + 3] = 64'h2000 + 64'(k);
  endtask

  task automatic put_link(input logic [63:0] head, input int n);
    mem[int'(head[8:3]) + 4 * (n - 1) + 2] = head;
  endtask

  task automatic kick(input logic [63:0] head, input int n, input bit cyc,
                      input bit rec);
    @(negedge clk);
    log_base    = log_n;
    cfg_head    = head;
    cfg_len     = 16'(n);
    cfg_cycle   = cyc;
    cfg_recycle = rec;
    start       = 1'b1;
    @(negedge clk);
    start       = 1'b0;
  endtask

  task automatic serve(input int k, input logic [63:0] src, input bit fl,
                       input string req);
    int t = 0;
    while (!xfer_valid && t < 2000) begin
      @(negedge clk);
      t++;
    end
    chk(xfer_valid, req, 64'(xfer_valid), 64'd1);
    chk(xfer_src == src, req, xfer_src, src);
    chk(xfer_dst == 64'h2000 + 64'(k), req, xfer_dst, 64'h2000 + 64'(k));
    chk(xfer_size == 32'h100 + 32'(k), "R3", 64'(xfer_size), 64'h100 + 64'(k));
    @(negedge clk);
    @(negedge clk);
    chk(xfer_valid && xfer_src == src, "R11", xfer_src, src);
    xfer_ready = 1'b1;
    @(negedge clk);
    xfer_ready = 1'b0;
    chk(!xfer_valid, "R5", 64'(xfer_valid), 64'd0);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(!rd_req_valid && !irq, "R5", 64'(rd_req_valid), 64'd0);
    end
    xfer_done = 1'b1;
    @(negedge clk);
    xfer_done = 1'b0;
    chk(irq == fl, "R6", 64'(irq), 64'(fl));
    @(negedge clk);
    chk(!irq, "R6", 64'(irq), 64'd0);
  endtask

  task automatic wait_idle(input string req);
    int t = 0;
    while (busy && t < 4000) begin
      @(negedge clk);
      t++;
    end
    chk(!busy && empty, req, {busy, empty}, 64'd1);
  endtask

  task automatic chk_log(input int i, input logic [63:0] exp, input string req);
    chk(rlog[log_base + i] == exp, req, rlog[log_base + i], exp);
  endtask

  task automatic t_reset;
    chk(!busy && !err && !empty && !irq && !rd_req_valid && !xfer_valid, "R1",
        {busy, err, empty, irq, rd_req_valid, xfer_valid}, 64'd0);
  endtask

  task automatic t_short;
    kick(64'h40, 1, 1'b1, 1'b1);
    chk(err && !busy, "R2", {err, busy}, 64'd2);
    kick(64'h40, 0, 1'b1, 1'b1);
    @(negedge clk);
    chk(err && !busy && log_n == log_base, "R2", 64'(log_n - log_base), 64'd0);
  endtask

  task automatic t_ring4;
    for (int k = 0; k < 3; k++) put_desc(64'h40, k, 1'b1, k == 1, 64'h1000 + 64'(k));
    put_link(64'h40, 4);
    kick(64'h40, 4, 1'b1, 1'b1);
    chk(!err, "R2", 64'(err), 64'd0);
    for (int k = 0; k < 3; k++) serve(k, 64'h1000 + 64'(k), k == 1, "R7");
    wait_idle("R8");
    chk(log_n - log_base == 14, "R4", 64'(log_n - log_base), 64'd14);
    for (int i = 0; i < 12; i++) chk_log(i, 64'h40 + 64'(8 * i), "R3");
    chk_log(12, 64'hB0, "R7");
    chk_log(13, 64'h40, "R7");
  endtask

  task automatic t_refill;
    for (int k = 0; k < 3; k++) put_desc(64'h40, k, 1'b1, 1'b0, 64'h1000 + 64'(k));
    kick(64'h40, 4, 1'b1, 1'b1);
    serve(0, 64'h1000, 1'b0, "R3");
    put_desc(64'h40, 0, 1'b0, 1'b1, 64'h3000);
    serve(1, 64'h1001, 1'b0, "R3");
    serve(2, 64'h1002, 1'b0, "R3");
    serve(0, 64'h3000, 1'b1, "R9");
    wait_idle("R9");
    chk(log_n - log_base == 18, "R9", 64'(log_n - log_base), 64'd18);
    chk_log(17, 64'h60, "R9");
  endtask

  task automatic t_norecycle;
    for (int k = 0; k < 3; k++) put_desc(64'h40, k, 1'b1, 1'b0, 64'h1000 + 64'(k));
    kick(64'h40, 4, 1'b1, 1'b0);
    for (int k = 0; k < 3; k++) serve(k, 64'h1000 + 64'(k), 1'b0, "R7");
    put_desc(64'h40, 1, 1'b0, 1'b0, 64'h1001);
    serve(0, 64'h1000, 1'b0, "R8");
    wait_idle("R8");
    chk(log_n - log_base == 18, "R8", 64'(log_n - log_base), 64'd18);
  endtask

  task automatic t_min;
    put_desc(64'h100, 0, 1'b0, 1'b1, 64'h5000);
    put_link(64'h100, 2);
    kick(64'h100, 2, 1'b0, 1'b1);
    serve(0, 64'h5000, 1'b1, "R10");
    wait_idle("R10");
    chk(log_n - log_base == 6, "R10", 64'(log_n - log_base), 64'd6);
    chk_log(4, 64'h130, "R10");
    chk_log(5, 64'h100, "R10");
  endtask

  task automatic t_first_miss;
    put_desc(64'h180, 0, 1'b0, 1'b0, 64'h6000);
    kick(64'h180, 3, 1'b1, 1'b1);
    wait_idle("R4");
    chk(log_n - log_base == 1, "R4", 64'(log_n - log_base), 64'd1);
    chk_log(0, 64'h180, "R4");
    chk(!xfer_valid, "R4", 64'(xfer_valid), 64'd0);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_short();
    t_ring4();
    t_refill();
    t_norecycle();
    t_min();
    t_first_miss();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule